// File: doc/BRIEF.md
# Per-Bit CRC Constant Table Builder

This block fills a small lookup table at run time for a wide parallel CRC datapath. For an input block of `BLK_W` bits and a CRC of width `CRC_W`, the table holds one `CRC_W`-bit constant per bit position. The constant at index j is the remainder of x^(CRC_W+j) divided by the generator. This is the checksum contribution of a lone 1 bit at position j. A wide datapath can then form the CRC of a block by XOR-ing the constants selected by the 1 bits of that block.

The generator polynomial is an input, so one instance serves any polynomial of the configured width. A single-cycle `start` latches the polynomial. The builder first reduces the value 1 for `CRC_W` cycles to obtain the constant for position 0. It then writes one constant per cycle, at rising indices. Each constant is the previous one multiplied by x and reduced. When the last index has been written, `done` is raised.

Top module: `crc_tab_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `tbl_we` and `done` are 0 and `tbl_idx` is 0.
- R2: A start that is accepted latches `poly`. Later changes of `poly` do not alter any table entry of that run.
- R3: `tbl_we` first goes high on the `CRC_W`-th rising edge after the edge that samples an accepted `start`.
- R4: Entry 0 equals x^CRC_W mod G. For `CRC_W`=32 and `poly`=0x04C11DB7, entry 0 is 0x04C11DB7. For `poly`=0, every entry is 0.
- R5: Entry j (j ≥ 1) equals entry j-1 shifted left by one bit, XOR-ed with `poly` when the bit shifted out of the MSB was 1.
- R6: A run writes exactly `BLK_W` entries, one per consecutive cycle, with `tbl_idx` going from 0 to `BLK_W`-1 in steps of one.
- R7: `done` rises on the edge after the write of index `BLK_W`-1. It is low while a run is in progress. It then stays high until a new start is accepted.
- R8: `start` is accepted only when no run is in progress (idle or done). A start during a run has no effect on that run.
- R9: Encoding: `poly` bit i is the coefficient of x^i, with x^CRC_W implicit. `tbl_data` bit i is the coefficient of x^i. For the CRC32 polynomial, entry 1 is 0x09823B6E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin building a table (accepted when idle or done) |
| poly | input | CRC_W | Generator coefficients below the leading term |
| tbl_we | output | 1 | Table write strobe |
| tbl_idx | output | $clog2(BLK_W) | Table write index (bit position) |
| tbl_data | output | CRC_W | Constant for that bit position |
| done | output | 1 | Table complete |

## Verification
The bound checker watches the write stream on every cycle. It checks that:
- a run opens at index 0;
- indices advance by one;
- each written constant follows from the previous one by the shift-and-reduce rule under the latched polynomial;
- `done` follows the last index and then holds;
- a start arriving mid-run never aborts the write sequence.

Only the bench scenarios can show the absolute values. These are entry 0 matching an independent long division, the seed latency of `CRC_W` cycles, and the insensitivity to `poly` changes and stray start pulses during a run. The bench compares every cycle against a behavioural model that divides x^(CRC_W+j) directly.

// File: rtl/crc_tab_pkg.sv
package crc_tab_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SEED,
        PH_EMIT,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/crc_tab_mulx.sv
// Multiply a remainder by x and reduce modulo the generator.
module crc_tab_mulx #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] poly,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = {cur[W-2:0], 1'b0} ^ (cur[W-1] ? poly : '0);
    end
endmodule

// File: rtl/crc_tab_seq.sv
// Phase and counter sequencing for the table builder.
module crc_tab_seq
    import crc_tab_pkg::*;
#(
    parameter  int CRC_W = 32,
    parameter  int BLK_W = 64,
    localparam int MAXN  = (CRC_W > BLK_W) ? CRC_W : BLK_W,
    localparam int CNT_W = $clog2(MAXN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             advance
);
    localparam logic [CNT_W-1:0] LAST_SEED = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(BLK_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        accept  = 1'b0;
        advance = 1'b0;
        case (st_q.phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    accept     = 1'b1;
                    st_d.phase = PH_SEED;
                    st_d.cnt   = '0;
                end
            end
            PH_SEED: begin
                advance = 1'b1;
                if (st_q.cnt == LAST_SEED) begin
                    st_d.phase = PH_EMIT;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_EMIT: begin
                advance = 1'b1;
                if (st_q.cnt == LAST_IDX) begin
                    st_d.phase = PH_DONE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign cnt   = st_q.cnt;
endmodule

// File: rtl/crc_tab_gen.sv
// Builds one CRC constant per input bit position, one write per cycle.
module crc_tab_gen
    import crc_tab_pkg::*;
#(
    parameter  int CRC_W = 32,
    parameter  int BLK_W = 64,
    localparam int IDX_W = $clog2(BLK_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CRC_W-1:0] poly,
    output logic             tbl_we,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [CRC_W-1:0] tbl_data,
    output logic             done
);
    localparam int MAXN  = (CRC_W > BLK_W) ? CRC_W : BLK_W;
    localparam int CNT_W = $clog2(MAXN + 1);

    typedef struct packed {
        logic [CRC_W-1:0] poly;
        logic [CRC_W-1:0] rem;
    } dp_t;

    dp_t              dp_d, dp_q;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             advance;
    logic [CRC_W-1:0] rem_next;
    logic [CRC_W-1:0] poly_q;

    crc_tab_seq #(.CRC_W(CRC_W), .BLK_W(BLK_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .phase   (phase),
        .cnt     (cnt),
        .accept  (accept),
        .advance (advance)
    );

    crc_tab_mulx #(.W(CRC_W)) u_mulx (
        .cur  (dp_q.rem),
        .poly (dp_q.poly),
        .nxt  (rem_next)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.poly = poly;
            dp_d.rem  = CRC_W'(1);
        end else if (advance) begin
            dp_d.rem = rem_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign poly_q   = dp_q.poly;
    assign tbl_we   = (phase == PH_EMIT);
    assign tbl_idx  = cnt[IDX_W-1:0];
    assign tbl_data = dp_q.rem;
    assign done     = (phase == PH_DONE);
endmodule

// File: rtl/crc_tab_gen_chk.sv
module crc_tab_gen_chk #(
    parameter  int CRC_W = 32,
    parameter  int BLK_W = 64,
    localparam int IDX_W = $clog2(BLK_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             tbl_we,
    input logic [IDX_W-1:0] tbl_idx,
    input logic [CRC_W-1:0] tbl_data,
    input logic             done,
    input logic [CRC_W-1:0] poly_q
);
    // R6: a run opens at index 0
    assert_first_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbl_we) |-> tbl_idx == '0);

    // R6: consecutive writes step the index by one
    assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && $past(tbl_we)) |-> tbl_idx == IDX_W'($past(tbl_idx) + 1'b1));

    // R5: each constant is the previous one times x, reduced
    assert_mulx_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && $past(tbl_we)) |->
        tbl_data == ({$past(tbl_data[CRC_W-2:0]), 1'b0} ^
                     ($past(tbl_data[CRC_W-1]) ? poly_q : '0)));

    // R7: done follows the last index
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && tbl_idx == IDX_W'(BLK_W - 1)) |=> done);

    // R7: done holds without a new start and never overlaps a write
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    assert_no_write_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> !done);

    // R8: a start during the write phase does not interrupt it
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && start) |=> (tbl_we || done));
endmodule

bind crc_tab_gen crc_tab_gen_chk #(.CRC_W(CRC_W), .BLK_W(BLK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tbl_we   (tbl_we),
    .tbl_idx  (tbl_idx),
    .tbl_data (tbl_data),
    .done     (done),
    .poly_q   (poly_q)
);

// File: tb/tb_crc_tab_gen.sv
`timescale 1ns/1ps
module tb_crc_tab_gen;
    localparam int CRC_W = 32;
    localparam int BLK_W = 64;
    localparam int IDX_W = $clog2(BLK_W);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CRC_W-1:0] poly = '0;
    logic             tbl_we;
    logic [IDX_W-1:0] tbl_idx;
    logic [CRC_W-1:0] tbl_data;
    logic             done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    crc_tab_gen #(.CRC_W(CRC_W), .BLK_W(BLK_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .poly(poly),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Remainder of x^(CRC_W+j) by long division
    function automatic logic [CRC_W-1:0] ref_entry(input logic [CRC_W-1:0] p, input int j);
        logic [CRC_W+BLK_W:0] dv;
        dv = '0;
        dv[CRC_W + j] = 1'b1;
        for (int b = CRC_W + j; b >= CRC_W; b--) begin
            if (dv[b]) dv[b -: CRC_W+1] = dv[b -: CRC_W+1] ^ {1'b1, p};
        end
        return dv[CRC_W-1:0];
    endfunction

    // Behavioural model: 0 idle, 1 seeding, 2 writing, 3 done
    int               m_mode = 0;
    int               m_sc = 0;
    int               m_k = 0;
    logic [CRC_W-1:0] m_tab [BLK_W];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_sc = 0; m_k = 0;
        end else begin
            case (m_mode)
                0, 3: if (start) begin
                    m_mode = 1; m_sc = 0;
                    for (int j = 0; j < BLK_W; j++) m_tab[j] = ref_entry(poly, j);
                end
                1: begin
                    m_sc++;
                    if (m_sc == CRC_W) begin m_mode = 2; m_k = 0; end
                end
                2: begin
                    m_k++;
                    if (m_k == BLK_W) m_mode = 3;
                end
                default: m_mode = 0;
            endcase
        end
    end

    // Per-cycle comparison plus capture of writes
    logic [CRC_W-1:0] cap [BLK_W];
    int wr_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(tbl_we == (m_mode == 2), "R6 we", 64'(tbl_we), 64'(m_mode == 2));
            check(done == (m_mode == 3), "R7 done", 64'(done), 64'(m_mode == 3));
            if (m_mode == 2 && tbl_we) begin
                check(tbl_idx == IDX_W'(m_k), "R6 idx", 64'(tbl_idx), 64'(m_k));
                check(tbl_data == m_tab[m_k], "R5 data", 64'(tbl_data), 64'(m_tab[m_k]));
            end
            if (tbl_we) begin
                cap[tbl_idx] = tbl_data;
                wr_cnt++;
            end
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(tbl_we == 1'b0, "R1 we", 64'(tbl_we), 64'd0);
        check(done == 1'b0, "R1 done", 64'(done), 64'd0);
        check(tbl_idx == '0, "R1 idx", 64'(tbl_idx), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tbl_we == 1'b0 && done == 1'b0, "R1 idle", 64'({tbl_we, done}), 64'd0);

        // Job A: CRC32 polynomial, latency and first entries
        wr_cnt = 0;
        poly = 32'h04C11DB7; start = 1'b1;
        @(negedge clk); start = 1'b0; n = 1;
        while (!tbl_we && n < 200) begin @(negedge clk); n++; end
        check(n == CRC_W + 1, "R3 latency", 64'(n), 64'(CRC_W + 1));
        wait_done();
        check(wr_cnt == BLK_W, "R6 count", 64'(wr_cnt), 64'(BLK_W));
        check(cap[0] == 32'h04C11DB7, "R4 entry0", 64'(cap[0]), 64'h04C11DB7);
        check(cap[1] == 32'h09823B6E, "R9 entry1", 64'(cap[1]), 64'h09823B6E);

        // R7: done holds with no start
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R7 hold", 64'(done), 64'd1);

        // Job B: restart from done, poly changes and stray starts mid-run
        wr_cnt = 0;
        poly = 32'h1EDC6F41; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        poly = 32'hFFFFFFFF; start = 1'b1;           // R8: during seeding
        @(negedge clk); start = 1'b0;
        while (!tbl_we) @(negedge clk);
        repeat (10) @(negedge clk);
        poly = 32'h00000005; start = 1'b1;           // R8: during writing
        @(negedge clk); start = 1'b0;
        wait_done();
        check(wr_cnt == BLK_W, "R8 count", 64'(wr_cnt), 64'(BLK_W));
        check(cap[0] == 32'h1EDC6F41, "R4 entry0 alt", 64'(cap[0]), 64'h1EDC6F41);
        check(cap[BLK_W-1] == ref_entry(32'h1EDC6F41, BLK_W-1), "R2 last",
              64'(cap[BLK_W-1]), 64'(ref_entry(32'h1EDC6F41, BLK_W-1)));

        // Job C: zero polynomial gives all-zero entries
        wr_cnt = 0;
        poly = '0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        check(cap[0] == '0, "R4 zero entry0", 64'(cap[0]), 64'd0);
        check(cap[BLK_W-1] == '0, "R4 zero last", 64'(cap[BLK_W-1]), 64'd0);
        check(wr_cnt == BLK_W, "R6 count zero", 64'(wr_cnt), 64'(BLK_W));

        // Job D: start held high, restarts right after done
        wr_cnt = 0;
        poly = 32'h000000AF; start = 1'b1;
        @(negedge clk);
        wait_done();
        @(negedge clk);
        check(done == 1'b0, "R7 restart", 64'(done), 64'd0);
        start = 1'b0;
        wait_done();
        check(wr_cnt == 2 * BLK_W, "R6 back-to-back", 64'(wr_cnt), 64'(2 * BLK_W));

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule